// File: doc/BRIEF.md
# Addressable LED Pulse-Width Encoder

This block turns a stream of 24-bit colour words into the single-wire pulse-width signal that drives chains of addressable RGB LEDs. A period counter runs from zero to its terminal count, and each period carries one data bit. A one is sent as a long high time and a zero as a short one. The output is high while the counter is below the active compare value.

The compare value is held in a shadow register. That register changes only at the counter wrap, so a period that has already started is never shortened. The next bit is also picked up at the wrap, and the first bit of a frame reaches the shadow register by the same path. When no further word is offered at the end of a word, the block sends one period with a compare value of zero. It then holds the line low for a latch interval, pulses done and stops itself. It stays stopped until start is asserted again.

Top module: `ledpw_encoder`

## Requirements
- R1: Every bit period lasts PERIOD clock cycles. The output is high for the first ONE_HI cycles of the period when the bit is one, and for the first ZERO_HI cycles when it is zero. It is low for the rest of the period.
- R2: Each word is sent from bit 23 down to bit 0. Green is in bits 23:16, red in 15:8 and blue in 7:0, so each colour goes out most significant bit first.
- R3: A start seen while idle raises busy on the next cycle and keeps the output low for one cycle. The period of bit 23 of the first word begins on the cycle after that. The first bit is sent exactly once.
- R4: col_ready is high only in the last cycle of a period, while running, once the current word is used up. That includes the arming cycle after start. An accepted word's bit 23 follows in the very next period with no gap.
- R5: If no word is valid when col_ready is high, exactly one full period with the output low follows.
- R6: After the low period of R5, the output stays low with busy high for LATCH_CYC cycles. Then busy falls and done is high for exactly that one cycle.
- R7: Once stopped, the block stays idle with col_ready low and the output low, even while a word is offered. A new start then sends a fresh frame identical in timing to the first.
- R8: A start asserted while busy has no effect on the waveform, busy or done.
- R9: After reset, dout, busy, done and col_ready are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a frame when idle |
| col_valid | input | 1 | Colour word offered |
| col_data | input | 24 | Colour word: green 23:16, red 15:8, blue 7:0 |
| col_ready | output | 1 | Colour word accepted this cycle when valid |
| dout | output | 1 | Serial LED data line |
| busy | output | 1 | Frame, tail or latch in progress |
| done | output | 1 | One-cycle pulse at end of latch interval |

## Verification
Frames are sent with no word at all, with a single mixed word, with runs containing all-zero and all-one words, and with a walking-one sweep of 24 words. These patterns show that bit order is correct in every position, that back-to-back words leave no gap, and that the zero-word case goes straight to the tail. Every output is compared on every cycle against an arithmetic model of period, phase and bit value. A late start inside a frame, and a word held valid while the block is stopped, show that both are ignored. A repeat frame shows that the restart matches the first frame cycle for cycle.

// File: rtl/ledpw_pkg.sv
package ledpw_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RUN   = 2'd1,
      ST_TAIL  = 2'd2,
      ST_LATCH = 2'd3
   } ledpw_state_e;
endpackage

// File: rtl/ledpw_period.sv
module ledpw_period #(
   parameter int PERIOD = 300,
   localparam int CW = $clog2(PERIOD)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          arm,
   input  logic          run,
   output logic [CW-1:0] cnt,
   output logic          wrap
);
   localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

   assign wrap = run && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (arm)   cnt <= LAST;
      else if (wrap)  cnt <= '0;
      else if (run)   cnt <= cnt + 1'b1;
      else            cnt <= '0;
   end
endmodule

// File: rtl/ledpw_shift.sv
module ledpw_shift #(
   parameter int WORD_W = 24,
   localparam int LW = $clog2(WORD_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   input  logic [WORD_W-1:0] word,
   output logic              next_bit,
   output logic              empty
);
   logic [WORD_W-1:0] sreg;
   logic [LW-1:0]     left;

   assign next_bit = sreg[WORD_W-1];
   assign empty    = (left == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg <= '0;
         left <= '0;
      end else if (load) begin
         sreg <= word << 1;
         left <= LW'(WORD_W - 1);
      end else if (step) begin
         sreg <= sreg << 1;
         left <= left - 1'b1;
      end
   end
endmodule

// File: rtl/ledpw_latch.sv
module ledpw_latch #(
   parameter int LATCH_CYC = 6250,
   localparam int LW = $clog2(LATCH_CYC + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic expire
);
   logic [LW-1:0] lcnt;

   assign expire = en && (lcnt == LW'(LATCH_CYC - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               lcnt <= '0;
      else if (!en || expire)   lcnt <= '0;
      else                      lcnt <= lcnt + 1'b1;
   end
endmodule

// File: rtl/ledpw_encoder.sv
module ledpw_encoder
   import ledpw_pkg::*;
#(
   parameter int PERIOD    = 300,
   parameter int ONE_HI    = 239,
   parameter int ZERO_HI   = 119,
   parameter int LATCH_CYC = 6250,
   parameter int WORD_W    = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              col_valid,
   input  logic [WORD_W-1:0] col_data,
   output logic              col_ready,
   output logic              dout,
   output logic              busy,
   output logic              done
);
   localparam int CW = $clog2(PERIOD);
   localparam logic [CW-1:0] CMP_ONE  = CW'(ONE_HI);
   localparam logic [CW-1:0] CMP_ZERO = CW'(ZERO_HI);

   if (PERIOD < 4)                      begin : g_bad_period $error("PERIOD too short"); end
   if (ONE_HI >= PERIOD)                begin : g_bad_one    $error("ONE_HI must be below PERIOD"); end
   if (ZERO_HI < 1 || ZERO_HI >= ONE_HI) begin : g_bad_zero $error("ZERO_HI must lie in 1..ONE_HI-1"); end
   if (LATCH_CYC < 1)                   begin : g_bad_latch  $error("LATCH_CYC must be positive"); end
   if (WORD_W % 8 != 0)                 begin : g_bad_word   $error("WORD_W must be whole bytes"); end

   ledpw_state_e  st;
   logic [CW-1:0] cnt, cmp_act;
   logic          wrap, arm, running, nxt_bit, sh_empty, sh_step, accept, expire;

   assign arm       = (st == ST_IDLE) && start;
   assign running   = (st == ST_RUN) || (st == ST_TAIL);
   assign col_ready = (st == ST_RUN) && wrap && sh_empty;
   assign accept    = col_ready && col_valid;
   assign sh_step   = (st == ST_RUN) && wrap && !sh_empty;
   assign busy      = (st != ST_IDLE);
   assign dout      = (cnt < cmp_act);

   ledpw_period #(.PERIOD(PERIOD)) u_period (
      .clk(clk), .rst_n(rst_n), .arm(arm), .run(running), .cnt(cnt), .wrap(wrap)
   );

   ledpw_shift #(.WORD_W(WORD_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(accept), .step(sh_step),
      .word(col_data), .next_bit(nxt_bit), .empty(sh_empty)
   );

   ledpw_latch #(.LATCH_CYC(LATCH_CYC)) u_latch (
      .clk(clk), .rst_n(rst_n), .en(st == ST_LATCH), .expire(expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         cmp_act <= '0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               cmp_act <= '0;
               if (start) st <= ST_RUN;
            end
            ST_RUN: if (wrap) begin
               if (!sh_empty)      cmp_act <= nxt_bit ? CMP_ONE : CMP_ZERO;
               else if (col_valid) cmp_act <= col_data[WORD_W-1] ? CMP_ONE : CMP_ZERO;
               else begin
                  cmp_act <= '0;
                  st      <= ST_TAIL;
               end
            end
            ST_TAIL: if (wrap) st <= ST_LATCH;
            ST_LATCH: if (expire) begin
               st   <= ST_IDLE;
               done <= 1'b1;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/ledpw_encoder_chk.sv
module ledpw_encoder_chk (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic col_valid,
   input logic col_ready,
   input logic dout,
   input logic busy,
   input logic done
);
   AST_READY_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      col_ready |-> busy); // R4
   AST_IDLE_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!dout && !col_ready)); // R7
   AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && !dout)); // R3
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R6
   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R6
   AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done); // R6
   AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> (busy || done)); // R8
endmodule

bind ledpw_encoder ledpw_encoder_chk u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .col_valid(col_valid),
   .col_ready(col_ready), .dout(dout), .busy(busy), .done(done)
);

// File: tb/sim_ledpw_encoder.sv
module sim_ledpw_encoder;
   localparam int P  = 20;
   localparam int H1 = 15;
   localparam int H0 = 7;
   localparam int L  = 30;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, col_valid = 1'b0;
   logic [23:0] col_data = '0;
   logic col_ready, dout, busy, done;
   int n_chk = 0, n_fail = 0;
   logic [23:0] wq [0:31];

   always #4 clk = ~clk;

   ledpw_encoder #(.PERIOD(P), .ONE_HI(H1), .ZERO_HI(H0), .LATCH_CYC(L)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .col_valid(col_valid),
      .col_data(col_data), .col_ready(col_ready), .dout(dout), .busy(busy), .done(done)
   );

   task automatic chk(input string req, input logic act, input logic exp, input int s);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s step %0d: actual %0b expected %0b", req, s, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   // n words from wq; a second start is pulsed at step restart_at (R8)
   task automatic run_frame(input int n, input int restart_at);
      int idx = 0;
      int s_done = 1 + (24*n + 1)*P + L;
      @(negedge clk);
      start = 1'b1;
      @(posedge clk);
      for (int s = 0; s <= s_done + 1; s++) begin
         logic exp_d, exp_b, exp_dn, exp_r, acc;
         int j, ph;
         string tag;
         @(negedge clk);
         col_valid = (idx < n);
         col_data  = (idx < n) ? wq[idx] : 24'h0;
         start     = (s == restart_at);
         #1;
         j  = (s == 0) ? -1 : (s - 1) / P;
         ph = (s == 0) ? 0 : (s - 1) % P;
         if (s == 0) begin exp_d = 1'b0; tag = "R3"; end
         else if (j < 24*n) begin
            exp_d = (ph < (wq[j/24][23 - (j%24)] ? H1 : H0));
            tag = (j == 0) ? "R3" : "R1 R2";
         end else if (j == 24*n) begin exp_d = 1'b0; tag = "R5"; end
         else begin exp_d = 1'b0; tag = "R6"; end
         exp_b  = (s < s_done);
         exp_dn = (s == s_done);
         exp_r  = (s % P == 0) && ((s / P) % 24 == 0) && (s / P <= 24*n);
         chk(tag, dout, exp_d, s);
         chk("R6 busy", busy, exp_b, s);
         chk("R6 done", done, exp_dn, s);
         chk("R4 ready", col_ready, exp_r, s);
         acc = col_valid && col_ready;
         @(posedge clk);
         if (acc) idx++;
      end
      @(negedge clk);
      start = 1'b0;
      col_valid = 1'b0;
   endtask

   initial begin
      #1_000_000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R9 dout", dout, 1'b0, 0);
      chk("R9 busy", busy, 1'b0, 0);
      chk("R9 done", done, 1'b0, 0);
      chk("R9 ready", col_ready, 1'b0, 0);
      rst_n = 1'b1;

      run_frame(0, -1);                 // R5: empty frame goes straight to tail
      wq[0] = 24'hA53C81;
      run_frame(1, -1);                 // R1 R2 single word
      wq[0] = 24'h000000; wq[1] = 24'hFFFFFF; wq[2] = 24'h5A0FF0;
      run_frame(3, 200);                // R4 back-to-back, R8 late start

      // R7: word offered while stopped is not taken
      @(negedge clk);
      col_valid = 1'b1; col_data = 24'hFFFFFF;
      for (int k = 0; k < 50; k++) begin
         @(negedge clk);
         chk("R7 ready", col_ready, 1'b0, k);
         chk("R7 dout", dout, 1'b0, k);
         chk("R7 busy", busy, 1'b0, k);
      end
      col_valid = 1'b0;

      run_frame(3, -1);                 // R7 restart identical frame
      for (int b = 0; b < 24; b++) wq[b] = 24'h1 << b;
      run_frame(24, -1);                // R2 walking one sweep

      summary();
      $finish;
   end
endmodule